// File: doc/BRIEF.md
# Dual-Band Tone Period Classifier

This block recognises a keypad tone pair from two squared signals. One carries the low-group band and one carries the high-group band, each already filtered and reduced to its sign. It times each signal from rising edge to rising edge, counting cycles of the reference clock. Each band is then classed as one of four nominal frequencies, or as none. When both bands hold a class, the block raises an early-detect flag and presents the 4-bit key code for the pair.

Before an edge is timed, each input passes through a two-stage synchroniser and a three-sample glitch filter. A band becomes valid only after a run of consecutive periods all land in the same acceptance window. One period outside every window clears that band. The band also clears when no edge arrives within a timeout of twice the longest accepted period of its lowest tone.

All period limits are computed at elaboration from the `CLK_HZ` parameter and the nominal frequencies. An inhibit input mutes the result.

Top module: `tone_pair_classifier`

## Requirements
- R1: The low band is classed as row 0..3 for the tones 697, 770, 852 and 941 Hz, in that order.
- R2: The high band is classed as column 0..3 for the tones 1209, 1336, 1477 and 1633 Hz, in that order.
- R3: A tone within ±(1.5% + 2 Hz) of its nominal frequency is accepted.
- R4: A tone 3.5% or more away from every nominal frequency of its band is rejected.
- R5: key_o encodes the pair as follows. For columns 0..2 and rows 0..2 the code is row*3+col+1, giving 1..9. On row 3, column 0 gives 11, column 1 gives 10 and column 2 gives 12. Column 3 gives 13, 14 and 15 for rows 0..2, and 0 for row 3. key_o is 0 whenever early_o is low.
- R6: A band becomes valid once NEED consecutive periods (default 4) land in the same window. Any out-of-window period clears the band at once.
- R7: A band with no qualified rising edge for twice the longest accepted period of its lowest tone is cleared. Before that limit it keeps its state.
- R8: early_o is high only while both bands are valid. It falls when either band is lost.
- R9: While inhibit_i is high, early_o and key_o are 0 from the next clock edge on.
- R10: An input pulse shorter than three clock samples creates no edge.
- R11: After reset, early_o and key_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| low_sq_i | input | 1 | Squared low-group band signal |
| high_sq_i | input | 1 | Squared high-group band signal |
| inhibit_i | input | 1 | Forces early_o and key_o to 0 |
| key_o | output | 4 | Key code of the detected pair |
| early_o | output | 1 | Early-detect flag |

## Verification
A valid band is due about seven clock cycles after the fifth qualified rising edge: two synchroniser stages, the filter history, the filter flag, the band register and the output register. An input period lasts hundreds of cycles, so the bench samples early_o and key_o on falling clock edges half a period after the result settles. Every sample therefore sits far from any edge that could still change them.

Clearing results follow the same rule. A bad period clears the band one output-register delay after the offending edge, and a timeout clears it one delay after the counter reaches its limit. Inhibit takes effect on the next clock edge. Each of these is checked a few cycles after its cause, with the opposite state checked well before its cause.

// File: rtl/tone_pkg.sv
package tone_pkg;

  // shortest accepted period in cycles: f*(1+1.5%)+2 Hz
  function automatic int unsigned per_min(int unsigned clk_hz, int unsigned f);
    longint unsigned num, den;
    num = longint'(clk_hz) * 1000;
    den = longint'(f) * 1015 + 2000;
    return int'(num / den);
  endfunction

  // longest accepted period in cycles: f*(1-1.5%)-2 Hz, rounded up
  function automatic int unsigned per_max(int unsigned clk_hz, int unsigned f);
    longint unsigned num, den;
    num = longint'(clk_hz) * 1000;
    den = longint'(f) * 985 - 2000;
    return int'((num + den - 1) / den);
  endfunction

  function automatic logic [3:0] key_code(logic [1:0] row, logic [1:0] col);
    if (col == 2'd3) return (row == 2'd3) ? 4'd0 : 4'(13 + int'(row));
    if (row == 2'd3) begin
      case (col)
        2'd0:    return 4'd11;
        2'd1:    return 4'd10;
        default: return 4'd12;
      endcase
    end
    return 4'(int'(row) * 3 + int'(col) + 1);
  endfunction

endpackage

// File: rtl/tone_edge_qual.sv
module tone_edge_qual #(
  parameter int unsigned FILT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sq_i,
  output logic rise_o
);
  logic [1:0]      sync_q;
  logic [FILT-1:0] hist_q;
  logic            filt_q, filt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
      filt_d <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], sq_i};
      hist_q <= {hist_q[FILT-2:0], sync_q[1]};
      if (&hist_q)       filt_q <= 1'b1;
      else if (~|hist_q) filt_q <= 1'b0;
      filt_d <= filt_q;
    end
  end

  assign rise_o = filt_q & ~filt_d;

  p_filter_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(filt_q) |-> $past(sync_q[1], 2));
  p_filter_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(filt_q) |-> !$past(sync_q[1], 2));
endmodule

// File: rtl/tone_band_meter.sv
module tone_band_meter
  import tone_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 3579545,
  parameter int unsigned FREQ [4] = '{697, 770, 852, 941},  // ascending
  parameter int unsigned NEED    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rise_i,
  output logic       valid_o,
  output logic [1:0] class_o
);
  localparam int unsigned NB  = 4;
  localparam int unsigned TMO = 2 * per_max(CLK_HZ, FREQ[0]);
  localparam int unsigned CW  = $clog2(TMO + 1);
  localparam int unsigned SW  = $clog2(NEED + 1);
  localparam logic [CW-1:0] TMO_C  = CW'(TMO);
  localparam logic [SW-1:0] NEED_C = SW'(NEED);

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] streak_q;
  logic [1:0]    cls_q;
  logic          started_q;
  logic [NB-1:0] hit;
  logic [1:0]    idx;
  logic          in_win;

  for (genvar k = 0; k < NB; k++) begin : g_win
    localparam int unsigned PMIN = per_min(CLK_HZ, FREQ[k]);
    localparam int unsigned PMAX = per_max(CLK_HZ, FREQ[k]);
    assign hit[k] = (cnt_q >= CW'(PMIN)) && (cnt_q <= CW'(PMAX));
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < NB; k++) if (hit[k]) idx = 2'(k);
  end
  assign in_win = |hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      streak_q  <= '0;
      cls_q     <= '0;
      started_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q     <= CW'(1);
      started_q <= 1'b1;
      if (started_q) begin
        if (in_win && idx == cls_q && streak_q != '0) begin
          if (streak_q != NEED_C) streak_q <= streak_q + 1'b1;
        end else if (in_win) begin
          cls_q    <= idx;
          streak_q <= SW'(1);
        end else begin
          streak_q <= '0;
        end
      end
    end else if (cnt_q >= TMO_C) begin
      started_q <= 1'b0;
      streak_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o = (streak_q == NEED_C);
  assign class_o = cls_q;

  p_valid_on_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(rise_i));
  p_bad_period_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && started_q && !in_win) |=> !valid_o);
  p_timeout_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && cnt_q >= TMO_C) |=> !valid_o);
endmodule

// File: rtl/tone_pair_classifier.sv
module tone_pair_classifier
  import tone_pkg::*;
#(
  parameter int unsigned CLK_HZ = 3579545,
  parameter int unsigned NEED   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       low_sq_i,
  input  logic       high_sq_i,
  input  logic       inhibit_i,
  output logic [3:0] key_o,
  output logic       early_o
);
  localparam int unsigned LOW_F  [4] = '{697, 770, 852, 941};
  localparam int unsigned HIGH_F [4] = '{1209, 1336, 1477, 1633};

  logic       lo_rise, hi_rise, lo_valid, hi_valid, pair_ok;
  logic [1:0] lo_cls, hi_cls;

  tone_edge_qual u_lo_edge (.clk_i, .rst_ni, .sq_i(low_sq_i),  .rise_o(lo_rise));
  tone_edge_qual u_hi_edge (.clk_i, .rst_ni, .sq_i(high_sq_i), .rise_o(hi_rise));

  tone_band_meter #(.CLK_HZ(CLK_HZ), .FREQ(LOW_F), .NEED(NEED)) u_lo_band (
    .clk_i, .rst_ni, .rise_i(lo_rise), .valid_o(lo_valid), .class_o(lo_cls));
  tone_band_meter #(.CLK_HZ(CLK_HZ), .FREQ(HIGH_F), .NEED(NEED)) u_hi_band (
    .clk_i, .rst_ni, .rise_i(hi_rise), .valid_o(hi_valid), .class_o(hi_cls));

  assign pair_ok = lo_valid & hi_valid & ~inhibit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      early_o <= 1'b0;
      key_o   <= '0;
    end else begin
      early_o <= pair_ok;
      key_o   <= pair_ok ? key_code(lo_cls, hi_cls) : 4'd0;
    end
  end

  p_inhibit_mutes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> (!early_o && key_o == 4'd0));
  p_early_needs_both_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |-> $past(lo_valid && hi_valid));
  p_key_zero_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !early_o |-> key_o == 4'd0);
endmodule

// File: tb/tone_pair_classifier_bench.sv
module tone_pair_classifier_bench;
  localparam int CLK_TB = 357954;  // scaled reference keeps runs short
  localparam int NV = 21;
  // low freq (0.1 Hz), high freq (0.1 Hz, 0 = off), expected early, expected key
  localparam int VEC [NV][4] = '{
    '{6970, 12090, 1, 1},  '{6970, 13360, 1, 2},  '{6970, 14770, 1, 3},  '{6970, 16330, 1, 13},
    '{7700, 12090, 1, 4},  '{7700, 13360, 1, 5},  '{7700, 14770, 1, 6},  '{7700, 16330, 1, 14},
    '{8520, 12090, 1, 7},  '{8520, 13360, 1, 8},  '{8520, 14770, 1, 9},  '{8520, 16330, 1, 15},
    '{9410, 12090, 1, 11}, '{9410, 13360, 1, 10}, '{9410, 14770, 1, 12}, '{9410, 16330, 1, 0},
    '{7054, 16134, 1, 13}, '{9297, 12235, 1, 11},
    '{7319, 13360, 0, 0},  '{8520, 14032, 0, 0},
    '{6970, 0, 0, 0}
  };

  logic clk = 0, rst_n = 0, lo_sq = 0, hi_sq = 0, inhibit = 0;
  logic [3:0] key;
  logic early;
  int lo_per = 0, hi_per = 0;
  bit glitch_en = 0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tone_pair_classifier #(.CLK_HZ(CLK_TB)) u_tone_pair_classifier (
    .clk_i(clk), .rst_ni(rst_n), .low_sq_i(lo_sq), .high_sq_i(hi_sq),
    .inhibit_i(inhibit), .key_o(key), .early_o(early));

  function automatic int per_of(int t);
    return (t == 0) ? 0 : (CLK_TB * 10 + t / 2) / t;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      if (lo_per == 0) begin
        lo_sq = 0;
        @(negedge clk);
      end else begin
        int p;
        p = lo_per;
        lo_sq = 1;
        wait_cyc(p / 2);
        lo_sq = 0;
        if (glitch_en) begin
          wait_cyc(p / 4);
          lo_sq = 1;
          wait_cyc(2);
          lo_sq = 0;
          wait_cyc(p - p / 2 - p / 4 - 2);
        end else begin
          wait_cyc(p - p / 2);
        end
      end
    end
  end

  initial begin
    forever begin
      if (hi_per == 0) begin
        hi_sq = 0;
        @(negedge clk);
      end else begin
        int p;
        p = hi_per;
        hi_sq = 1;
        wait_cyc(p / 2);
        hi_sq = 0;
        wait_cyc(p - p / 2);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    chk("R11 early", int'(early), 0);
    chk("R11 key", int'(key), 0);
    rst_n = 1;
    wait_cyc(4);
    chk("R11 early after release", int'(early), 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      int lp;
      tag = (i < 16) ? "R1/R2" : (i < 18) ? "R3" : (i < 20) ? "R4" : "R8";
      lp = per_of(VEC[i][0]);
      lo_per = lp;
      hi_per = per_of(VEC[i][1]);
      wait_cyc(lp * 11 / 2);
      chk($sformatf("%s early vec %0d", tag, i), int'(early), VEC[i][2]);
      chk($sformatf("R5 key vec %0d", i), int'(key), VEC[i][3]);
      lo_per = 0;
      hi_per = 0;
      wait_cyc(1800);
    end

    // R6: three periods are not enough, five edges are
    lo_per = per_of(6970);
    hi_per = per_of(12090);
    wait_cyc(lo_per * 7 / 2);
    chk("R6 early after three periods", int'(early), 0);
    wait_cyc(lo_per * 2);
    chk("R6 early after five edges", int'(early), 1);
    chk("R6 key", int'(key), 1);

    // R6: one out-of-window period clears the band
    lo_per = per_of(7319);
    wait_cyc(1100);
    chk("R6 bad period clears", int'(early), 0);
    chk("R6 key cleared", int'(key), 0);
    lo_per = per_of(6970);
    wait_cyc(514 * 6);
    chk("R6 recovers", int'(early), 1);

    // R10: short pulses inside the low phase are filtered
    glitch_en = 1;
    wait_cyc(514 * 3);
    chk("R10 glitch ignored early", int'(early), 1);
    chk("R10 glitch ignored key", int'(key), 1);
    glitch_en = 0;
    wait_cyc(514);

    // R9: inhibit mutes and releases
    inhibit = 1;
    wait_cyc(3);
    chk("R9 inhibit early", int'(early), 0);
    chk("R9 inhibit key", int'(key), 0);
    inhibit = 0;
    wait_cyc(3);
    chk("R9 release early", int'(early), 1);
    chk("R9 release key", int'(key), 1);

    // R7/R8: silence on the high band times it out
    hi_per = 0;
    wait_cyc(100);
    chk("R7 held before timeout", int'(early), 1);
    wait_cyc(900);
    chk("R7 cleared after timeout", int'(early), 0);
    chk("R8 key after loss", int'(key), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule